// File: doc/BRIEF.md
# Chained Input Serializer Readout Engine

This block acts as an SPI master that reads a daisy chain of identical industrial input serializers in a single chip-select frame. Each chip in the chain delivers eight input levels. When the chain runs in status mode, each chip also sends a diagnostic byte. The diagnostic byte carries a 5-bit check code over the input byte, an overtemperature indication and two supply-voltage indications. The engine also samples an external fault line, which can be one line per chip or one line shared by all chips. From these it derives a per-chip "bad" flag, so the host can use the inputs of healthy chips and discard those of a failing chip in the same chain.

The host raises a request to start a readout. When the frame ends, every captured input byte and every diagnostic flag is updated in the same clock cycle, and a one-cycle done pulse acts as the acknowledge. The frame format, the undervoltage-ignore option and the serial clock divider are taken from the configuration inputs at the moment the request is accepted.

Top module: `serchain_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, done is low, and every captured input bit and diagnostic flag is zero.
- R2: A frame holds chip select low for exactly 8·CHIPS serial clock rising edges in byte mode (status_mode=0) and 16·CHIPS in status mode (status_mode=1). The serial clock idles low and MISO is sampled on its rising edge. Each clock phase lasts clk_div+1 system clocks, so chip select stays low for 2·bits·(clk_div+1) cycles.
- R3: Bytes arrive MSB first, and the first byte received belongs to chip 0. In status mode chip i sends its input byte at frame byte 2i and its status byte at 2i+1; in byte mode its input byte is frame byte i. Chip i's inputs appear on in_bits[8i+7:8i].
- R4: In status mode crc_err[i] is set when status bits [7:3] differ from the CRC of the input byte. The CRC uses polynomial x^5+x^4+x^2+1, a zero initial value, and processes the byte MSB first.
- R5: In status mode, status bit 1 high sets overtemp[i], status bit 2 low sets uv_alarm[i], and status bit 0 low sets uv_warn[i].
- R6: chip_bad[i] is set by fault_seen[i], or in status mode by crc_err[i], overtemp[i] or uv_alarm[i]. uv_warn[i] on its own never sets it.
- R7: With ignore_uv=1, uv_alarm, uv_warn and fault_seen are all zero and the fault lines have no effect on chip_bad.
- R8: With fault_shared=1, fault_in[0] applies to every chip and the other fault_in bits are not used. With fault_shared=0, fault_in[i] applies to chip i only.
- R9: In byte mode crc_err, overtemp, uv_alarm and uv_warn are zero, and chip_bad equals fault_seen.
- R10: A request raised while a frame is in progress is ignored. That frame completes with one done pulse and no second frame follows.
- R11: All outputs change together in the cycle done is high. Done lasts one cycle, and the outputs hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Readout request, accepted only when idle |
| status_mode | input | 1 | 1: input plus status byte per chip; 0: input byte only |
| ignore_uv | input | 1 | Suppress voltage flags and fault-line sampling |
| fault_shared | input | 1 | 1: fault_in[0] serves all chips |
| fault_in | input | CHIPS | External fault lines, active high |
| clk_div | input | DIV_W | Serial clock phase length minus one, in system clocks |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_miso | input | 1 | Serial data from the chain |
| busy | output | 1 | Frame in progress |
| rd_done | output | 1 | One-cycle completion pulse |
| in_bits | output | 8·CHIPS | Captured input levels, chip i in bits 8i+7:8i |
| crc_err | output | CHIPS | Per-chip check-code mismatch |
| overtemp | output | CHIPS | Per-chip overtemperature |
| uv_alarm | output | CHIPS | Per-chip undervoltage alarm |
| uv_warn | output | CHIPS | Per-chip undervoltage warning |
| fault_seen | output | CHIPS | Per-chip fault line sampled high |
| chip_bad | output | CHIPS | Per-chip inputs not trustworthy |

## Verification
Internal state that goes wrong shows up at the ports within one frame. A bit counter or frame length that is off changes the number of serial clock edges and the time chip select stays low. A mistake in byte placement moves input bytes between chips, or sends a status byte to the wrong chip. A wrong check-code or status decode gives wrong flags in the done cycle of the very next readout. Errors in the mode latch, the ignore latch or the request gating show as flags that should be zero, or as a chip-select fall after done without a fresh request. Each scenario is therefore judged at its done pulse and in the cycles that follow.

// File: rtl/serchain_reader.sv
module serchain_reader #(
  parameter int CHIPS = 2,
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic               status_mode,
  input  logic               ignore_uv,
  input  logic               fault_shared,
  input  logic [CHIPS-1:0]   fault_in,
  input  logic [DIV_W-1:0]   clk_div,
  output logic               spi_sclk,
  output logic               spi_cs_n,
  input  logic               spi_miso,
  output logic               busy,
  output logic               rd_done,
  output logic [8*CHIPS-1:0] in_bits,
  output logic [CHIPS-1:0]   crc_err,
  output logic [CHIPS-1:0]   overtemp,
  output logic [CHIPS-1:0]   uv_alarm,
  output logic [CHIPS-1:0]   uv_warn,
  output logic [CHIPS-1:0]   fault_seen,
  output logic [CHIPS-1:0]   chip_bad
);
  localparam int FRAME_MAX = 16 * CHIPS;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  logic                 mode_q, ign_q;
  logic [DIV_W-1:0]     div_q, div_cnt;
  logic [CNT_W-1:0]     bit_cnt, nbits;
  logic [FRAME_MAX-1:0] shreg;

  logic [8*CHIPS-1:0] nx_in;
  logic [CHIPS-1:0]   nx_crc, nx_ot, nx_uva, nx_uvw, nx_flt;

  function automatic logic [4:0] crc5(input logic [7:0] d);
    logic [4:0] c;
    c = '0;
    for (int b = 7; b >= 0; b--) begin
      if (c[4] ^ d[b]) c = {c[3:0], 1'b0} ^ 5'h15;
      else             c = {c[3:0], 1'b0};
    end
    return c;
  endfunction

  assign nbits = mode_q ? CNT_W'(FRAME_MAX) : CNT_W'(8 * CHIPS);

  for (genvar g = 0; g < CHIPS; g++) begin : g_chip
    logic [7:0] din, st;
    logic       line;
    assign din  = mode_q ? shreg[FRAME_MAX-1-16*g -: 8] : shreg[8*CHIPS-1-8*g -: 8];
    assign st   = shreg[FRAME_MAX-9-16*g -: 8];
    assign line = fault_shared ? fault_in[0] : fault_in[g];
    assign nx_in[8*g +: 8] = din;
    assign nx_crc[g] = mode_q && (st[7:3] != crc5(din));
    assign nx_ot[g]  = mode_q && st[1];
    assign nx_uva[g] = mode_q && !ign_q && !st[2];
    assign nx_uvw[g] = mode_q && !ign_q && !st[0];
    assign nx_flt[g] = !ign_q && line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_sclk   <= 1'b0;
      spi_cs_n   <= 1'b1;
      busy       <= 1'b0;
      rd_done    <= 1'b0;
      mode_q     <= 1'b0;
      ign_q      <= 1'b0;
      div_q      <= '0;
      div_cnt    <= '0;
      bit_cnt    <= '0;
      shreg      <= '0;
      in_bits    <= '0;
      crc_err    <= '0;
      overtemp   <= '0;
      uv_alarm   <= '0;
      uv_warn    <= '0;
      fault_seen <= '0;
      chip_bad   <= '0;
    end else begin
      rd_done <= 1'b0;
      if (!busy) begin
        if (rd_req) begin
          busy     <= 1'b1;
          spi_cs_n <= 1'b0;
          mode_q   <= status_mode;
          ign_q    <= ignore_uv;
          div_q    <= clk_div;
          div_cnt  <= '0;
          bit_cnt  <= '0;
          shreg    <= '0;
        end
      end else if (div_cnt == div_q) begin
        div_cnt <= '0;
        if (!spi_sclk) begin
          spi_sclk <= 1'b1;
          shreg    <= {shreg[FRAME_MAX-2:0], spi_miso};
        end else begin
          spi_sclk <= 1'b0;
          bit_cnt  <= bit_cnt + CNT_W'(1);
          if (bit_cnt == nbits - CNT_W'(1)) begin
            busy       <= 1'b0;
            spi_cs_n   <= 1'b1;
            rd_done    <= 1'b1;
            in_bits    <= nx_in;
            crc_err    <= nx_crc;
            overtemp   <= nx_ot;
            uv_alarm   <= nx_uva;
            uv_warn    <= nx_uvw;
            fault_seen <= nx_flt;
            chip_bad   <= nx_flt | nx_crc | nx_ot | nx_uva;
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done); // R11
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_done |-> $stable(chip_bad) && $stable(in_bits)); // R11
  AST_IDLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n); // R2
  AST_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk); // R2
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || ($stable(mode_q) && $stable(ign_q) && $stable(div_q))); // R10
  AST_WARN_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> (chip_bad & ~(fault_seen | crc_err | overtemp | uv_alarm)) == '0); // R6
  AST_IGNORE_UV: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && ign_q |-> (uv_alarm | uv_warn | fault_seen) == '0); // R7
  AST_BYTE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && !mode_q |-> (crc_err | overtemp | uv_alarm | uv_warn) == '0); // R9
endmodule

// File: tb/test_serchain_reader.sv
module test_serchain_reader;
  localparam int CHIPS = 2;

  logic clk = 1'b0, rst_n = 1'b0, rd_req = 1'b0;
  logic status_mode = 1'b0, ignore_uv = 1'b0, fault_shared = 1'b0, spi_miso = 1'b0;
  logic [CHIPS-1:0] fault_in = '0;
  logic [7:0] clk_div = 8'd1;
  logic spi_sclk, spi_cs_n, busy, rd_done;
  logic [8*CHIPS-1:0] in_bits;
  logic [CHIPS-1:0] crc_err, overtemp, uv_alarm, uv_warn, fault_seen, chip_bad;

  int checks = 0, errors = 0, rises = 0;

  always #2.5 clk = ~clk;
  always @(posedge spi_sclk) rises++;

  serchain_reader #(.CHIPS(CHIPS), .DIV_W(8)) i_serchain_reader (
    .clk, .rst_n, .rd_req, .status_mode, .ignore_uv, .fault_shared, .fault_in,
    .clk_div, .spi_sclk, .spi_cs_n, .spi_miso, .busy, .rd_done, .in_bits,
    .crc_err, .overtemp, .uv_alarm, .uv_warn, .fault_seen, .chip_bad);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] ref_crc(input logic [7:0] d);
    logic [12:0] r;
    r = {d, 5'b0};
    for (int i = 12; i >= 5; i--)
      if (r[i]) r[i -: 6] = r[i -: 6] ^ 6'b110101;
    return r[4:0];
  endfunction

  function automatic logic [7:0] stat(input logic [7:0] d, input logic ot,
                                      input logic uva, input logic uvw, input logic bad);
    return {ref_crc(d) ^ {4'b0, bad}, ~uva, ot, ~uvw};
  endfunction

  int cs_low;
  int dones;

  task automatic slave(input logic [31:0] stream, input int nbits);
    @(negedge spi_cs_n);
    spi_miso = stream[nbits-1];
    for (int k = 1; k < nbits; k++) begin
      @(negedge spi_sclk);
      spi_miso = stream[nbits-1-k];
    end
  endtask

  task automatic run_frame(input logic sm, input logic ig, input logic sh,
                           input logic [1:0] flt, input logic [31:0] stream,
                           input logic [7:0] div, input logic poke);
    @(negedge clk);
    status_mode = sm; ignore_uv = ig; fault_shared = sh; fault_in = flt; clk_div = div;
    rises = 0; cs_low = 0; dones = 0;
    fork
      slave(stream, sm ? 32 : 16);
      begin
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        for (int w = 0; !rd_done; w++) begin
          if (!spi_cs_n) cs_low++;
          if (poke && w == 10) rd_req = 1'b1;
          if (poke && w == 12) rd_req = 1'b0;
          @(negedge clk);
        end
        dones = 1;
      end
    join
    @(negedge clk);
    chk("R11 done lasts one cycle", rd_done, 0);
  endtask

  task automatic t_reset;
    chk("R1 cs idle", spi_cs_n, 1);
    chk("R1 sclk idle", spi_sclk, 0);
    chk("R1 done low", rd_done, 0);
    chk("R1 inputs zero", in_bits, 0);
    chk("R1 flags zero", {crc_err, overtemp, uv_alarm, uv_warn, fault_seen, chip_bad}, 0);
  endtask

  task automatic t_byte_mode;
    run_frame(0, 0, 0, 2'b00, {16'h0, 8'hA5, 8'h3C}, 8'd0, 0);
    chk("R2 byte mode edges", rises, 16);
    chk("R2 byte mode cs low", cs_low, 32);
    chk("R3 byte mode order", in_bits, 16'h3CA5);
    chk("R9 byte mode flags", {crc_err, overtemp, uv_alarm, uv_warn, chip_bad}, 0);
  endtask

  task automatic t_status_good;
    run_frame(1, 0, 0, 2'b00, {8'h81, stat(8'h81,0,0,0,0), 8'h7E, stat(8'h7E,0,0,0,0)}, 8'd0, 0);
    chk("R2 status edges", rises, 32);
    chk("R2 status cs low", cs_low, 64);
    chk("R3 status order", in_bits, 16'h7E81);
    chk("R4 good crc", crc_err, 0);
    chk("R6 healthy chain", chip_bad, 0);
  endtask

  task automatic t_status_faults;
    run_frame(1, 0, 0, 2'b00, {8'h5A, stat(8'h5A,0,0,0,1), 8'hC3, stat(8'hC3,1,0,0,0)}, 8'd1, 0);
    chk("R4 crc mismatch chip0", crc_err, 2'b01);
    chk("R5 overtemp chip1", overtemp, 2'b10);
    chk("R6 both bad", chip_bad, 2'b11);
    chk("R3 inputs kept", in_bits, 16'hC35A);
  endtask

  task automatic t_undervolt;
    run_frame(1, 0, 0, 2'b00, {8'h11, stat(8'h11,0,1,0,0), 8'h22, stat(8'h22,0,0,1,0)}, 8'd1, 0);
    chk("R5 uv alarm", uv_alarm, 2'b01);
    chk("R5 uv warn", uv_warn, 2'b10);
    chk("R6 warn alone not bad", chip_bad, 2'b01);
  endtask

  task automatic t_ignore_uv;
    run_frame(1, 1, 0, 2'b11, {8'h11, stat(8'h11,0,1,1,0), 8'h22, stat(8'h22,0,1,1,0)}, 8'd1, 0);
    chk("R7 uv flags suppressed", {uv_alarm, uv_warn}, 0);
    chk("R7 fault lines ignored", fault_seen, 0);
    chk("R7 nothing bad", chip_bad, 0);
  endtask

  task automatic t_fault_lines;
    logic [31:0] good;
    good = {8'h81, stat(8'h81,0,0,0,0), 8'h7E, stat(8'h7E,0,0,0,0)};
    run_frame(1, 0, 0, 2'b10, good, 8'd1, 0);
    chk("R8 per-chip fault", fault_seen, 2'b10);
    chk("R6 fault marks chip1", chip_bad, 2'b10);
    run_frame(1, 0, 1, 2'b01, good, 8'd1, 0);
    chk("R8 shared fault all chips", chip_bad, 2'b11);
    run_frame(1, 0, 1, 2'b10, good, 8'd1, 0);
    chk("R8 shared uses line 0 only", fault_seen, 2'b00);
  endtask

  task automatic t_byte_fault_div;
    run_frame(0, 0, 0, 2'b01, {16'h0, 8'hF0, 8'h0F}, 8'd3, 0);
    chk("R2 divider cs low", cs_low, 128);
    chk("R9 byte mode fault only", chip_bad, 2'b01);
    chk("R9 byte mode no status flags", {crc_err, overtemp, uv_alarm, uv_warn}, 0);
    chk("R3 byte mode data", in_bits, 16'h0FF0);
  endtask

  task automatic t_busy_request;
    logic [15:0] held;
    run_frame(0, 0, 0, 2'b00, {16'h0, 8'h96, 8'h69}, 8'd1, 1);
    chk("R10 frame length unchanged", rises, 16);
    held = in_bits;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!spi_cs_n || rd_done) begin
        chk("R10 no second frame", {spi_cs_n, rd_done}, 2'b10);
        break;
      end
    end
    chk("R11 outputs hold", in_bits, held);
    chk("R10 data of first frame", held, 16'h6996);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_byte_mode;
    t_status_good;
    t_status_faults;
    t_undervolt;
    t_ignore_uv;
    t_fault_lines;
    t_byte_fault_div;
    t_busy_request;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule